// File: doc/BRIEF.md
# Serial DAC Register Interface

This block is the digital front end of a serial-input digital-to-analog converter. It runs on a fast system clock and oversamples a slow serial interface. That interface has a serial clock, an active-low frame strobe, a data line, an active-low load strobe, an active-low readback enable, an active-low clear and a power-down request. A 16-bit word shifts in MSB first on falling serial-clock edges while the frame strobe is low. The low `DATA_W` bits (12 or 14) are the converter code and the upper bits are dropped. The output code register that drives the converter is updated at frame end, or later by a load pulse, depending on the load strobe level seen when the frame opened.

A clear request forces the converter to its ground-referenced level through a flag and leaves every register as it was. The previous code comes back once clear is released and the load strobe is low. Readback copies the holding register, zero-extended to 16 bits, into the shift register. The serial output always shows the shift register MSB, so written words reappear 16 clocks later for chaining devices. The power-down request only raises a flag for the analog section.

The frame controller has three states. **IDLE**: no frame. **FRAME**: the strobe is low and falling serial-clock edges are counted. **PEND**: a complete word is waiting for a load pulse. Transitions:
- IDLE→FRAME and PEND→FRAME on a strobe fall, which also latches the load level.
- FRAME→IDLE on a strobe rise. This commits the word when exactly 16 edges arrived with load low, and discards it on any other edge count.
- FRAME→PEND on a strobe rise after 16 edges with load high.
- PEND→IDLE when load goes low, which commits the word.

Top module: `sdac_frontend`

## Requirements
- R1: After reset the output code, holding register and shift register are zero, the clear flag is low, the power-down flag is low and the serial output is low.
- R2: A 16-bit frame is taken MSB first, and only its low `DATA_W` bits (14 by default) reach the code; upper bits have no effect (word 0xC123 gives code 0x0123).
- R3: If load is low when the strobe falls, the holding register and output code take the new value when the strobe rises.
- R4: If load is high when the strobe falls, the strobe rise changes nothing; the word is loaded when load is later driven low.
- R5: A frame ending with a falling-edge count other than 16 (15 or 17) changes neither the holding register nor the output code.
- R6: A clear fall sets the clear flag and leaves the output code and holding register unchanged; frames accepted during clear update the holding register only.
- R7: The clear flag drops, and the output code is reloaded from the holding register, only when clear is high and load is low.
- R8: After readback enable falls, the next serial-clock fall loads {zeros, holding register} into the shift register; following falls with readback enable low shift it out MSB first.
- R9: The serial output is the shift register MSB, so during a frame the previous word appears on it MSB first, one bit per falling edge.
- R10: The power-down flag follows its input and does not change the holding register or output code.
- R11: Serial-clock falls while both the strobe and readback enable are high leave the shift register, and so the serial output, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, idles high |
| sync_n_i | input | 1 | Active-low frame strobe |
| sdin_i | input | 1 | Serial data in |
| ldac_n_i | input | 1 | Active-low load strobe |
| rben_n_i | input | 1 | Active-low readback enable |
| clr_n_i | input | 1 | Active-low clear to ground level |
| pwrdn_i | input | 1 | Power-down request |
| code_o | output | DATA_W | Code driving the converter |
| clear_o | output | 1 | Force output to ground-referenced level |
| pdown_o | output | 1 | Low-power flag |
| sdo_o | output | 1 | Serial data out (shift register MSB) |

## Verification
The assertions assume that every serial input holds each level for several system clocks, so that no edge is lost in the two-stage synchronizer. They also assume that data is stable a few clocks before each serial-clock fall. The bench keeps to this by changing inputs only on falling system-clock edges and holding every level for at least three clocks. It sets the data line before lowering the serial clock. It never toggles the serial clock while a deferred word is pending, and it never overlaps a readback with a write frame.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    localparam int WORD_W = 16;

    // Bit positions inside the bundled input vector
    localparam int IN_SCLK  = 0;
    localparam int IN_SYNC  = 1;
    localparam int IN_SDIN  = 2;
    localparam int IN_LDAC  = 3;
    localparam int IN_RBEN  = 4;
    localparam int IN_CLR   = 5;
    localparam int IN_PWRDN = 6;
    localparam int IN_W     = 7;

    // Idle levels seen before and after reset
    localparam logic [IN_W-1:0] IN_IDLE = 7'b0111011;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_PEND  = 2'd2
    } frame_state_e;
endpackage

// File: rtl/sdac_in_sync.sv
module sdac_in_sync #(
    parameter int              W      = 7,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    IDLE   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] fall_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] pipe [STAGES];
    logic [W-1:0] prev_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[0] <= IDLE;
                    else        pipe[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= IDLE;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= pipe[STAGES-1];
    end

    assign lvl_o  = pipe[STAGES-1];
    assign fall_o = prev_q & ~pipe[STAGES-1];
    assign rise_o = ~prev_q & pipe[STAGES-1];
endmodule

// File: rtl/sdac_frame_fsm.sv
module sdac_frame_fsm
    import sdac_pkg::*;
#(
    parameter int BITS = WORD_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_fall_i,
    input  logic sync_rise_i,
    input  logic sclk_fall_i,
    input  logic ldac_n_i,
    output logic commit_o,
    output logic abort_o,
    output logic frame_o,
    output logic pend_o
);
    localparam int CNT_W   = $clog2(BITS + 2);
    localparam int CNT_MAX = BITS + 1;

    frame_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             lat_q, lat_d;
    logic             full;

    assign full = (cnt_q == CNT_W'(BITS));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            lat_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lat_q   <= lat_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lat_d   = lat_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sync_fall_i) begin
                    state_d = ST_FRAME;
                    cnt_d   = '0;
                    lat_d   = ldac_n_i;
                end
            end
            ST_FRAME: begin
                if (sync_rise_i) begin
                    if (full && lat_q) state_d = ST_PEND;
                    else               state_d = ST_IDLE;
                end else if (sclk_fall_i && cnt_q != CNT_W'(CNT_MAX)) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_PEND: begin
                if (sync_fall_i) begin
                    state_d = ST_FRAME;
                    cnt_d   = '0;
                    lat_d   = ldac_n_i;
                end else if (!ldac_n_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        commit_o = 1'b0;
        abort_o  = 1'b0;
        frame_o  = 1'b0;
        pend_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FRAME: begin
                frame_o = 1'b1;
                if (sync_rise_i) begin
                    commit_o = full && !lat_q;
                    abort_o  = !full;
                end
            end
            ST_PEND: begin
                pend_o   = 1'b1;
                commit_o = !ldac_n_i;
            end
            default: ;
        endcase
    end

    // R5: the edge counter never runs past its saturation value
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CNT_MAX));
    // R3: a commit and a discard never coincide
    assert_commit_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && abort_o));
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
    import sdac_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_fall_i,
    input  logic              frame_i,
    input  logic              sync_n_i,
    input  logic              rben_n_i,
    input  logic              rben_fall_i,
    input  logic              sdin_i,
    input  logic [DATA_W-1:0] hold_i,
    output logic [WORD_W-1:0] sreg_o,
    output logic              sdo_o
);
    localparam int PAD_W = WORD_W - DATA_W;

    logic [WORD_W-1:0] sreg_q;
    logic              rb_arm_q;
    logic              rb_load;
    logic              shift_en;
    logic [WORD_W-1:0] rb_word;

    generate
        if (PAD_W > 0) begin : g_pad
            assign rb_word = {{PAD_W{1'b0}}, hold_i};
        end else begin : g_nopad
            assign rb_word = hold_i[WORD_W-1:0];
        end
    endgenerate

    assign rb_load  = sclk_fall_i && (rb_arm_q || rben_fall_i);
    assign shift_en = sclk_fall_i && (frame_i || !rben_n_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q   <= '0;
            rb_arm_q <= 1'b0;
        end else begin
            if (rb_load) begin
                sreg_q   <= rb_word;
                rb_arm_q <= 1'b0;
            end else begin
                if (rben_fall_i) rb_arm_q <= 1'b1;
                if (shift_en)
                    sreg_q <= {sreg_q[WORD_W-2:0], frame_i ? sdin_i : 1'b0};
            end
        end
    end

    assign sreg_o = sreg_q;
    assign sdo_o  = sreg_q[WORD_W-1];

    // R8: a readback load leaves the padding bits zero
    generate
        if (PAD_W > 0) begin : g_rb_chk
            assert_rb_pad_R8: assert property (@(posedge clk) disable iff (!rst_n)
                rb_load |=> sreg_q[WORD_W-1:DATA_W] == '0);
        end
    endgenerate

    // R11: with strobe and readback enable high, serial clocks do not disturb the register
    assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall_i && sync_n_i && rben_n_i && !frame_i && !rb_arm_q) |=> $stable(sreg_q));
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
    import sdac_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sync_n_i,
    input  logic              sdin_i,
    input  logic              ldac_n_i,
    input  logic              rben_n_i,
    input  logic              clr_n_i,
    input  logic              pwrdn_i,
    output logic [DATA_W-1:0] code_o,
    output logic              clear_o,
    output logic              pdown_o,
    output logic              sdo_o
);
    logic [IN_W-1:0]   raw, lvl, fall, rise;
    logic              commit, abort, frame, pend;
    logic [WORD_W-1:0] sreg;
    logic [DATA_W-1:0] hold_q, hold_d, code_q;
    logic              clear_q, pdown_q, release_c;

    assign raw[IN_SCLK]  = sclk_i;
    assign raw[IN_SYNC]  = sync_n_i;
    assign raw[IN_SDIN]  = sdin_i;
    assign raw[IN_LDAC]  = ldac_n_i;
    assign raw[IN_RBEN]  = rben_n_i;
    assign raw[IN_CLR]   = clr_n_i;
    assign raw[IN_PWRDN] = pwrdn_i;

    sdac_in_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .IDLE(IN_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw),
        .lvl_o(lvl), .fall_o(fall), .rise_o(rise)
    );

    sdac_frame_fsm #(.BITS(WORD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sync_fall_i(fall[IN_SYNC]), .sync_rise_i(rise[IN_SYNC]),
        .sclk_fall_i(fall[IN_SCLK]), .ldac_n_i(lvl[IN_LDAC]),
        .commit_o(commit), .abort_o(abort), .frame_o(frame), .pend_o(pend)
    );

    sdac_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_fall_i(fall[IN_SCLK]), .frame_i(frame),
        .sync_n_i(lvl[IN_SYNC]), .rben_n_i(lvl[IN_RBEN]),
        .rben_fall_i(fall[IN_RBEN]), .sdin_i(lvl[IN_SDIN]),
        .hold_i(hold_q), .sreg_o(sreg), .sdo_o(sdo_o)
    );

    assign hold_d    = commit ? sreg[DATA_W-1:0] : hold_q;
    assign release_c = clear_q && lvl[IN_CLR] && !lvl[IN_LDAC] && !fall[IN_CLR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            code_q  <= '0;
            clear_q <= 1'b0;
            pdown_q <= 1'b0;
        end else begin
            hold_q  <= hold_d;
            pdown_q <= lvl[IN_PWRDN];
            if (fall[IN_CLR]) begin
                clear_q <= 1'b1;
            end else if (release_c) begin
                clear_q <= 1'b0;
                code_q  <= hold_d;
            end else if (commit && !clear_q) begin
                code_q  <= hold_d;
            end
        end
    end

    assign code_o  = code_q;
    assign clear_o = clear_q;
    assign pdown_o = pdown_q;

    // R3: a commit loads the data field of the shift register
    assert_commit_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> hold_q == $past(sreg[DATA_W-1:0]));
    // R4: a pending word waits while load stays high
    assert_pend_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && lvl[IN_LDAC]) |=> $stable(hold_q));
    // R5: a discarded frame changes nothing
    assert_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> ($stable(hold_q) && $stable(code_q)));
    // R6: the code is frozen while clear stays active
    assert_clear_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_q && $past(clear_q)) |-> $stable(code_q));
    // R7: clear only drops with clear released and load low
    assert_clear_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clear_q) |-> ($past(lvl[IN_CLR]) && !$past(lvl[IN_LDAC])));
endmodule

// File: tb/sdac_frontend_test.sv
module sdac_frontend_test;
    localparam int DW = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, sync_n = 1'b1, sdin = 1'b0, ldac_n = 1'b1;
    logic rben_n = 1'b1, clr_n = 1'b1, pwrdn = 1'b0;
    logic [DW-1:0] code;
    logic clear, pdown, sdo;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [DW-1:0] exp_code = '0;

    always #10 clk = ~clk;

    sdac_frontend #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sync_n_i(sync_n),
        .sdin_i(sdin), .ldac_n_i(ldac_n), .rben_n_i(rben_n), .clr_n_i(clr_n),
        .pwrdn_i(pwrdn), .code_o(code), .clear_o(clear), .pdown_o(pdown),
        .sdo_o(sdo)
    );

    // {word, deferred-load flag, expected code}
    localparam logic [30:0] VECS [6] = '{
        {16'hFFFF, 1'b0, 14'h3FFF},
        {16'h0000, 1'b0, 14'h0000},
        {16'hC123, 1'b0, 14'h0123},
        {16'h2AAA, 1'b1, 14'h2AAA},
        {16'h5555, 1'b1, 14'h1555},
        {16'h8001, 1'b0, 14'h0001}
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clock_bit(input logic b);
        sdin = b;
        wait_clk(3);
        sclk = 1'b0;
        wait_clk(5);
        sclk = 1'b1;
        wait_clk(3);
    endtask

    task automatic send_frame(input logic [15:0] w, input int nbits, input bit ldac_low);
        ldac_n = !ldac_low;
        wait_clk(4);
        sync_n = 1'b0;
        wait_clk(6);
        for (int i = 0; i < nbits; i++) clock_bit(i < 16 ? w[15-i] : 1'b0);
        sync_n = 1'b1;
        wait_clk(6);
        ldac_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic ldac_pulse();
        ldac_n = 1'b0;
        wait_clk(6);
        ldac_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic read_back(output logic [15:0] rd);
        rd = '0;
        rben_n = 1'b0;
        wait_clk(6);
        for (int i = 0; i < 16; i++) begin
            sclk = 1'b0;
            wait_clk(6);
            rd = {rd[14:0], sdo};
            sclk = 1'b1;
            wait_clk(4);
        end
        rben_n = 1'b1;
        wait_clk(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R1 reset state
        check("R1 code", code, 0);
        check("R1 clear", clear, 0);
        check("R1 pdown", pdown, 0);
        check("R1 sdo", sdo, 0);

        // Vector table: R2, R3, R4
        for (int v = 0; v < 6; v++) begin
            logic [15:0] w;
            logic        dfr;
            logic [DW-1:0] e;
            {w, dfr, e} = VECS[v];
            send_frame(w, 16, !dfr);
            if (dfr) begin
                check("R4 no load at strobe rise", code, exp_code);
                ldac_pulse();
            end
            exp_code = e;
            check(dfr ? "R4 deferred load" : "R3/R2 immediate load", code, exp_code);
        end

        // R11: shift register holds 0x8001, idle clocks must not move sdo
        check("R11 sdo before", sdo, 1);
        for (int i = 0; i < 3; i++) clock_bit(1'b0);
        check("R11 sdo after idle clocks", sdo, 1);

        // R5: short and long frames
        send_frame(16'h1234, 15, 1'b1);
        check("R5 short frame", code, exp_code);
        send_frame(16'h1234, 17, 1'b1);
        check("R5 long frame", code, exp_code);

        // R8 readback
        read_back(rd);
        check("R8 readback", rd, {2'b00, exp_code});

        // R9 daisy chain: previous word appears on sdo during next frame
        send_frame(16'hB00F, 16, 1'b1);
        exp_code = 14'h300F;
        check("R2 upper bits dropped", code, exp_code);
        ldac_n = 1'b0;
        wait_clk(4);
        sync_n = 1'b0;
        wait_clk(6);
        rd = {15'd0, sdo};
        for (int i = 0; i < 16; i++) begin
            sdin = 1'(16'h1E5A >> (15 - i));
            wait_clk(3);
            sclk = 1'b0;
            wait_clk(5);
            if (i < 15) rd = {rd[14:0], sdo};
            sclk = 1'b1;
            wait_clk(3);
        end
        sync_n = 1'b1;
        wait_clk(6);
        ldac_n = 1'b1;
        wait_clk(6);
        check("R9 daisy output", rd, 16'hB00F);
        exp_code = 14'h1E5A;
        check("R3 daisy frame load", code, exp_code);

        // R6 / R7 clear
        clr_n = 1'b0;
        wait_clk(6);
        check("R6 clear set", clear, 1);
        check("R6 code kept", code, exp_code);
        read_back(rd);
        check("R6 holding register kept", rd, {2'b00, exp_code});
        send_frame(16'h0ABC, 16, 1'b1);
        check("R6 code frozen during clear", code, exp_code);
        clr_n = 1'b1;
        wait_clk(6);
        check("R7 clear held with load high", clear, 1);
        ldac_pulse();
        exp_code = 14'h0ABC;
        check("R7 clear dropped", clear, 0);
        check("R7 code restored", code, exp_code);

        // R10 power-down
        pwrdn = 1'b1;
        wait_clk(6);
        check("R10 pdown set", pdown, 1);
        check("R10 code kept", code, exp_code);
        pwrdn = 1'b0;
        wait_clk(6);
        check("R10 pdown clear", pdown, 0);

        // R1 reset again
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
        check("R1 code after reset", code, 0);
        check("R1 sdo after reset", sdo, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule